// File: doc/BRIEF.md
# Peripheral Handshake Control-Line Unit

This block manages the two control lines that belong to one parallel port of a peripheral interface. The first control line is an input only: the block watches it for a programmed edge (rising or falling) and raises an interrupt flag when that edge appears. The second control line is bidirectional. It can act as an edge-sensing input, or as an output that the block drives as a handshake, as a one-clock strobe, or as a static level. When the first line sees its active edge, the block can also capture the port's 8-bit input into a holding latch. The latch is not overwritten while the flag for that line is still pending.

The block owns the interrupt flag and enable registers of the port. A host access to the port data register acknowledges the pending line flags and starts an output handshake or strobe. Writing ones to the flag register clears the matching flags. The enable register is written in set/clear form, where bit 7 of the write data selects set or clear. Flag bit 7 is a summary bit: it is high when any flag is set and its enable bit is also set. Flag sources outside this block, such as timers, enter on a separate set input for flag bits 6:2. All logic runs on one clock. Each edge is found by comparing a line with its level registered on the previous clock.

Top module: `hsk_ctrl_unit`

## Requirements
- R1: While reset is asserted (synchronous, active low), flags_o reads 0, ien_o reads 0, line2_o is high and the capture latch holds 0.
- R2: An edge on line1_i sets flags_o[1] at the first clock edge at which the new level is sampled. edge1_rise_i=1 selects rising edges and edge1_rise_i=0 selects falling edges. An edge of the other polarity does not set the flag.
- R3: Modes 0 to 3 of line2_mode_i are input modes, and in them line2_oe is 0. Mode bit 1 selects the edge that sets flags_o[0] from line2_i: 0 selects falling and 1 selects rising. Mode bit 0 marks the independent variants, modes 1 and 3.
- R4: Mode 4 is handshake output. After a host access (data_access_i high for one cycle), line2_o goes low one clock later and stays low. A falling edge on line1_i then drives line2_o high and sets flags_o[0].
- R5: Mode 5 is pulse output. After a host access, line2_o goes low one clock later for exactly one clock, then returns high.
- R6: Mode 6 forces line2_o low and mode 7 forces it high, from the next clock on. Line2_oe is 1 in modes 4 to 7.
- R7: If latch_en_i is 1 when the line1 active edge occurs and flags_o[1] was still clear, port_i is captured and port_data_o shows the captured value. While flags_o[1] is set, later edges do not change the capture. When latch_en_i is 0, port_data_o follows port_i directly.
- R8: A host access clears flags_o[1] and flags_o[0]. In the independent modes 1 and 3, flags_o[0] is left unchanged.
- R9: When flag_wr_i is high, each 1 in flag_wdata_i[6:0] clears the matching flag. A flag set in the same cycle wins over the clear. ext_flag_set_i[k] sets flag bit k+2.
- R10: When ien_wr_i is high and ien_wdata_i[7] is 1, the enable bits selected by ien_wdata_i[6:0] are set. When ien_wdata_i[7] is 0, the selected enable bits are cleared. Unselected bits keep their value.
- R11: flags_o[7] is 1 exactly when flags_o[6:0] and ien_o share a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line1_i | input | 1 | Edge-sensing control line |
| line2_i | input | 1 | Pin level of the bidirectional control line |
| line2_o | output | 1 | Driven level of the bidirectional control line |
| line2_oe | output | 1 | Output enable of the bidirectional control line |
| port_i | input | 8 | External parallel port value |
| port_data_o | output | 8 | Captured port value, or port_i when capture is off |
| edge1_rise_i | input | 1 | Line1 active edge: 1 rising, 0 falling |
| line2_mode_i | input | 3 | Line2 mode code (0 to 7, see R3 to R6) |
| latch_en_i | input | 1 | Enables input capture on the line1 edge |
| data_access_i | input | 1 | One-cycle strobe for a host access to the port data register |
| ext_flag_set_i | input | 5 | Set requests for flag bits 6:2 |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag write data, where ones clear |
| ien_wr_i | input | 1 | Enable register write strobe |
| ien_wdata_i | input | 8 | Enable write data; bit 7 chooses set or clear |
| flags_o | output | 8 | Flag register, with the summary in bit 7 |
| ien_o | output | 7 | Enable register |

## Verification
The bench targets edges of the wrong polarity. A design that ignored the polarity control would set a flag on them. It also repeats line1 edges while flags_o[1] is pending, and a latch that was not frozen would show the newer port value. In pulse mode it checks how long line2_o stays low: a design that mis-sequenced the strobe would hold it low for two clocks, or never let it return high. In handshake mode it checks that line2_o stays low until line1 falls. For acknowledges in the independent modes, a design that cleared flag 0 anyway would lose that flag. A randomized phase mixes enable set/clear writes, flag clears and external sets in the same cycle. Wrong clear/set priority or a stale summary bit would show as a flag or summary mismatch.

// File: rtl/hsk_pkg.sv
// Package: shared mode codes and helpers for the handshake control-line unit.
// Assumes: the 3-bit mode code is decoded exactly as listed in l2_mode_e.
package hsk_pkg;

    typedef enum logic [2:0] {
        L2_IN_FALL   = 3'd0,
        L2_IRQ_FALL  = 3'd1,
        L2_IN_RISE   = 3'd2,
        L2_IRQ_RISE  = 3'd3,
        L2_HANDSHAKE = 3'd4,
        L2_PULSE     = 3'd5,
        L2_FORCE_LO  = 3'd6,
        L2_FORCE_HI  = 3'd7
    } l2_mode_e;

    // Input modes have bit 2 clear.
    function automatic logic mode_is_input(input l2_mode_e m);
        return ~m[2];
    endfunction

    // Independent input modes leave flag 0 alone on a host access.
    function automatic logic mode_is_indep(input l2_mode_e m);
        return ~m[2] & m[0];
    endfunction

    // Bit 1 picks the rising edge in the input modes.
    function automatic logic mode_wants_rise(input l2_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/hsk_edge_det.sv
// Module: hsk_edge_det
// Finds rising and falling edges of a level by comparing it with the
// value it had on the previous clock.
// Assumes: level_i is synchronous to clk. During reset the history
// register tracks the level, so releasing reset creates no edge.
module hsk_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Purpose: remember the level of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= level_i;
        else        prev_q <= level_i;
    end

    // Purpose: compare current and previous level.
    always_comb begin
        rise_o = level_i & ~prev_q;
        fall_o = ~level_i & prev_q;
    end

endmodule

// File: rtl/hsk_line2_ctl.sv
// Module: hsk_line2_ctl
// Drives and senses the bidirectional control line. A host access posts a
// request. On the next clock the request drives the line low, and in pulse
// mode it also schedules the return to high one clock later. Handshake mode
// releases the line on a falling edge of line 1. In the input modes the
// module reports the selected edge of the pin.
// Assumes: access_i is a single-cycle strobe.
module hsk_line2_ctl
    import hsk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  l2_mode_e mode_i,
    input  logic     access_i,
    input  logic     l1_fall_i,
    input  logic     pin_i,
    output logic     drive_o,
    output logic     oe_o,
    output logic     flag_set_o
);

    logic drv_q, req_q, ret_q;
    logic drv_n, req_n, ret_n;
    logic eff_lvl, eff_rise, eff_fall;

    // Purpose: select the level the edge detector watches.
    always_comb begin
        oe_o    = ~mode_is_input(mode_i);
        eff_lvl = oe_o ? drv_q : pin_i;
    end

    hsk_edge_det u_eff_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (eff_lvl),
        .rise_o  (eff_rise),
        .fall_o  (eff_fall)
    );

    // Purpose: sequence the request and return steps, then apply the mode.
    always_comb begin
        drv_n = drv_q;
        req_n = req_q;
        ret_n = ret_q;
        if (ret_q) begin
            drv_n = 1'b1;
            ret_n = 1'b0;
        end else if (req_q) begin
            drv_n = 1'b0;
            ret_n = (mode_i == L2_PULSE);
            req_n = 1'b0;
        end
        if (access_i && (mode_i == L2_HANDSHAKE || mode_i == L2_PULSE))
            req_n = 1'b1;
        case (mode_i)
            L2_HANDSHAKE: if (l1_fall_i) drv_n = 1'b1;
            L2_FORCE_LO:  drv_n = 1'b0;
            L2_FORCE_HI:  drv_n = 1'b1;
            default:      ;
        endcase
    end

    // Purpose: flag-0 set request from the pin edge or the handshake reply.
    always_comb begin
        if (mode_is_input(mode_i))
            flag_set_o = mode_wants_rise(mode_i) ? eff_rise : eff_fall;
        else if (mode_i == L2_HANDSHAKE)
            flag_set_o = l1_fall_i;
        else
            flag_set_o = 1'b0;
    end

    // Purpose: hold the driven level and the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= 1'b1;
            req_q <= 1'b0;
            ret_q <= 1'b0;
        end else begin
            drv_q <= drv_n;
            req_q <= req_n;
            ret_q <= ret_n;
        end
    end

    assign drive_o = drv_q;

endmodule

// File: rtl/hsk_port_latch.sv
// Module: hsk_port_latch
// Captures the parallel port on the line-1 active edge, but only while
// the line-1 flag is clear, so that the capture stays frozen until the
// flag is acknowledged.
// Assumes: flag_pending_i is the registered flag value, not its next state.
module hsk_port_latch #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              en_i,
    input  logic              flag_pending_i,
    input  logic [PORT_W-1:0] port_i,
    output logic [PORT_W-1:0] held_o,
    output logic [PORT_W-1:0] data_o
);

    logic [PORT_W-1:0] held_q;

    // Purpose: store the port value on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (capture_i && en_i && !flag_pending_i)
            held_q <= port_i;
    end

    // Purpose: present the capture or the live port.
    always_comb begin
        held_o = held_q;
        data_o = en_i ? held_q : port_i;
    end

endmodule

// File: rtl/hsk_irq_regs.sv
// Module: hsk_irq_regs
// Flag and enable registers. Set requests win over clears in the same
// cycle. The top flag bit is a registered summary of enabled pending flags.
// Assumes: the top bit of each register is reserved for the summary or
// for the set/clear selector.
module hsk_irq_regs #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-2:0] set_i,
    input  logic [FLAG_W-2:0] ack_clr_i,
    input  logic              flag_wr_i,
    input  logic [FLAG_W-1:0] flag_wdata_i,
    input  logic              ien_wr_i,
    input  logic [FLAG_W-1:0] ien_wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-2:0] ien_o
);

    localparam int SRC_W = FLAG_W - 1;

    logic [SRC_W-1:0] flag_q, flag_n;
    logic [SRC_W-1:0] ien_q, ien_n;
    logic [SRC_W-1:0] wr_clr;
    logic             sum_q;

    assign wr_clr = flag_wr_i ? flag_wdata_i[SRC_W-1:0] : '0;

    // Purpose: per-bit next state of flags and enables.
    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        always_comb begin
            flag_n[b] = (flag_q[b] & ~(wr_clr[b] | ack_clr_i[b])) | set_i[b];
            if (ien_wr_i && ien_wdata_i[b])
                ien_n[b] = ien_wdata_i[FLAG_W-1];
            else
                ien_n[b] = ien_q[b];
        end
    end

    // Purpose: register flags, enables and the summary bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            ien_q  <= '0;
            sum_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            ien_q  <= ien_n;
            sum_q  <= |(flag_n & ien_n);
        end
    end

    assign flags_o = {sum_q, flag_q};
    assign ien_o   = ien_q;

endmodule

// File: rtl/hsk_ctrl_unit.sv
// Module: hsk_ctrl_unit (top)
// Control-line unit for one parallel port: line-1 edge sensing, line-2
// mode handling, port input capture, and the flag/enable registers.
// Assumes: single clock domain; inputs are already synchronized; the
// host access strobe lasts one cycle.
module hsk_ctrl_unit
    import hsk_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line1_i,
    input  logic              line2_i,
    output logic              line2_o,
    output logic              line2_oe,
    input  logic [PORT_W-1:0] port_i,
    output logic [PORT_W-1:0] port_data_o,
    input  logic              edge1_rise_i,
    input  logic [2:0]        line2_mode_i,
    input  logic              latch_en_i,
    input  logic              data_access_i,
    input  logic [FLAG_W-4:0] ext_flag_set_i,
    input  logic              flag_wr_i,
    input  logic [FLAG_W-1:0] flag_wdata_i,
    input  logic              ien_wr_i,
    input  logic [FLAG_W-1:0] ien_wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-2:0] ien_o
);

    localparam int SRC_W = FLAG_W - 1;

    l2_mode_e          mode;
    logic              l1_rise, l1_fall, l1_edge;
    logic              l2_flag_set;
    logic [SRC_W-1:0]  set_vec, ack_vec;
    logic [PORT_W-1:0] held_val;

    assign mode = l2_mode_e'(line2_mode_i);

    hsk_edge_det u_l1_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (line1_i),
        .rise_o  (l1_rise),
        .fall_o  (l1_fall)
    );

    // Purpose: active line-1 edge per the polarity control.
    assign l1_edge = edge1_rise_i ? l1_rise : l1_fall;

    hsk_line2_ctl u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .access_i   (data_access_i),
        .l1_fall_i  (l1_fall),
        .pin_i      (line2_i),
        .drive_o    (line2_o),
        .oe_o       (line2_oe),
        .flag_set_o (l2_flag_set)
    );

    hsk_port_latch #(.PORT_W(PORT_W)) u_latch (
        .clk            (clk),
        .rst_n          (rst_n),
        .capture_i      (l1_edge),
        .en_i           (latch_en_i),
        .flag_pending_i (flags_o[1]),
        .port_i         (port_i),
        .held_o         (held_val),
        .data_o         (port_data_o)
    );

    // Purpose: gather flag set and acknowledge-clear vectors.
    always_comb begin
        set_vec    = {ext_flag_set_i, l1_edge, l2_flag_set};
        ack_vec    = '0;
        ack_vec[1] = data_access_i;
        ack_vec[0] = data_access_i & ~mode_is_indep(mode);
    end

    hsk_irq_regs #(.FLAG_W(FLAG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_vec),
        .ack_clr_i    (ack_vec),
        .flag_wr_i    (flag_wr_i),
        .flag_wdata_i (flag_wdata_i),
        .ien_wr_i     (ien_wr_i),
        .ien_wdata_i  (ien_wdata_i),
        .flags_o      (flags_o),
        .ien_o        (ien_o)
    );

endmodule

// File: rtl/hsk_ctrl_unit_chk.sv
// Module: hsk_ctrl_unit_chk
// Property checker bound to hsk_ctrl_unit. It observes ports and the
// internal edge and capture signals.
// Assumes: default widths of the top module.
module hsk_ctrl_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] line2_mode_i,
    input logic       line2_o,
    input logic [7:0] flags_o,
    input logic [6:0] ien_o,
    input logic       ien_wr_i,
    input logic [7:0] ien_wdata_i,
    input logic [7:0] held_val,
    input logic       l1_edge
);

    p_edge_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l1_edge |=> flags_o[1]);

    p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line2_mode_i == 3'd5 && $past(line2_mode_i) == 3'd5 && $fell(line2_o))
        |=> (line2_o || line2_mode_i != 3'd5));

    p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line2_mode_i == 3'd6) |=> !line2_o);

    p_force_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line2_mode_i == 3'd7) |=> line2_o);

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1] |=> $stable(held_val));

    p_ien_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr_i && ien_wdata_i[7])
        |=> ((ien_o & $past(ien_wdata_i[6:0])) == $past(ien_wdata_i[6:0])));

    p_ien_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr_i && !ien_wdata_i[7])
        |=> ((ien_o & $past(ien_wdata_i[6:0])) == 7'd0));

    p_summary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[7] == (|(flags_o[6:0] & ien_o)));

endmodule

bind hsk_ctrl_unit hsk_ctrl_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line2_mode_i (line2_mode_i),
    .line2_o      (line2_o),
    .flags_o      (flags_o),
    .ien_o        (ien_o),
    .ien_wr_i     (ien_wr_i),
    .ien_wdata_i  (ien_wdata_i),
    .held_val     (held_val),
    .l1_edge      (l1_edge)
);

// File: tb/hsk_ctrl_unit_tb.sv
// Bench for hsk_ctrl_unit: directed corner cases, then a seeded random
// phase on the flag/enable registers checked against a bench model.
`timescale 1ns/1ps
module hsk_ctrl_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line1 = 1'b0, l2_in = 1'b0;
    logic       line2_o, line2_oe;
    logic [7:0] port = 8'h00, pdata;
    logic       pol = 1'b0, latch_en = 1'b0, access = 1'b0;
    logic [2:0] mode = 3'd7;
    logic [4:0] ext_set = 5'd0;
    logic       flag_wr = 1'b0, ien_wr = 1'b0;
    logic [7:0] flag_wd = 8'd0, ien_wd = 8'd0;
    logic [7:0] flags;
    logic [6:0] ien;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hsk_ctrl_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .line1_i        (line1),
        .line2_i        (l2_in),
        .line2_o        (line2_o),
        .line2_oe       (line2_oe),
        .port_i         (port),
        .port_data_o    (pdata),
        .edge1_rise_i   (pol),
        .line2_mode_i   (mode),
        .latch_en_i     (latch_en),
        .data_access_i  (access),
        .ext_flag_set_i (ext_set),
        .flag_wr_i      (flag_wr),
        .flag_wdata_i   (flag_wd),
        .ien_wr_i       (ien_wr),
        .ien_wdata_i    (ien_wd),
        .flags_o        (flags),
        .ien_o          (ien)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_flags(input logic [7:0] m);
        flag_wr = 1'b1; flag_wd = m; tick();
        flag_wr = 1'b0; flag_wd = 8'd0;
    endtask

    task automatic pulse_access();
        access = 1'b1; tick(); access = 1'b0;
    endtask

    function automatic logic [6:0] model_ien(input logic [6:0] cur, input logic wr, input logic [7:0] wd);
        if (!wr) return cur;
        return wd[7] ? (cur | wd[6:0]) : (cur & ~wd[6:0]);
    endfunction

    function automatic logic [6:0] model_flags(input logic [6:0] cur, input logic wr,
                                               input logic [7:0] wd, input logic [4:0] ext);
        logic [6:0] c;
        c = wr ? wd[6:0] : 7'd0;
        return (cur & ~c) | {ext, 2'b00};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [6:0] fm, im;
        void'($urandom(32'd20240611));
        latch_en = 1'b1; port = 8'hA5;
        repeat (3) tick();
        // R1 reset state
        check("R1 flags", flags, 8'h00);
        check("R1 ien", ien, 7'h00);
        check("R1 line2 high", line2_o, 1'b1);
        check("R1 capture zero", pdata, 8'h00);
        latch_en = 1'b0; port = 8'h00;
        rst_n = 1'b1; tick();

        // R6 forced levels
        mode = 3'd6; tick();
        check("R6 force low", line2_o, 1'b0);
        check("R6 oe", line2_oe, 1'b1);
        mode = 3'd7; tick();
        check("R6 force high", line2_o, 1'b1);

        // R2 falling polarity
        line1 = 1'b1; tick();
        check("R2 rising ignored when falling chosen", flags[1], 1'b0);
        line1 = 1'b0; tick();
        check("R2 falling sets flag1", flags[1], 1'b1);
        clear_flags(8'h02);
        check("R9 write-one clears flag1", flags[1], 1'b0);
        // R2 rising polarity
        pol = 1'b1; line1 = 1'b1; tick();
        check("R2 rising sets flag1", flags[1], 1'b1);
        clear_flags(8'h02);

        // R3 input modes
        l2_in = 1'b1; mode = 3'd2; tick();
        check("R3 oe low in input mode", line2_oe, 1'b0);
        check("R3 no flag on mode switch", flags[0], 1'b0);
        l2_in = 1'b0; tick();
        check("R3 falling ignored in rising mode", flags[0], 1'b0);
        l2_in = 1'b1; tick();
        check("R3 rising sets flag0", flags[0], 1'b1);
        clear_flags(8'h01);
        mode = 3'd0; l2_in = 1'b0; tick();
        check("R3 falling sets flag0 in mode 0", flags[0], 1'b1);
        clear_flags(8'h01);

        // R8 acknowledge in independent and plain modes
        mode = 3'd1; l2_in = 1'b1; tick();
        l2_in = 1'b0; tick();
        check("R3 independent falling sets flag0", flags[0], 1'b1);
        line1 = 1'b0; tick();
        line1 = 1'b1; tick();
        check("R2 flag1 before access", flags[1], 1'b1);
        pulse_access();
        check("R8 independent keeps flag0, clears flag1", flags[1:0], 2'b01);
        mode = 3'd0; pulse_access();
        check("R8 access clears flag0", flags[1:0], 2'b00);

        // R7 capture and freeze
        latch_en = 1'b1; port = 8'h3C; line1 = 1'b0; tick();
        line1 = 1'b1; tick();
        check("R7 capture on edge", pdata, 8'h3C);
        port = 8'hC3; line1 = 1'b0; tick();
        line1 = 1'b1; tick();
        check("R7 frozen while flag1 pending", pdata, 8'h3C);
        clear_flags(8'h02);
        line1 = 1'b0; tick();
        line1 = 1'b1; tick();
        check("R7 capture after acknowledge", pdata, 8'hC3);
        latch_en = 1'b0; port = 8'h5A; #1;
        check("R7 live port when capture off", pdata, 8'h5A);
        clear_flags(8'hFF);

        // R4 handshake
        mode = 3'd4; tick();
        check("R4 idle high", line2_o, 1'b1);
        pulse_access();
        check("R4 not yet low", line2_o, 1'b1);
        tick();
        check("R4 low after request", line2_o, 1'b0);
        tick();
        check("R4 stays low", line2_o, 1'b0);
        check("R4 no flag0 yet", flags[0], 1'b0);
        line1 = 1'b0; tick();
        check("R4 line1 fall releases line2", line2_o, 1'b1);
        check("R4 line1 fall sets flag0", flags[0], 1'b1);

        // R5 pulse
        mode = 3'd5; clear_flags(8'hFF);
        pulse_access();
        check("R5 high at access", line2_o, 1'b1);
        tick();
        check("R5 low one clock", line2_o, 1'b0);
        tick();
        check("R5 returns high", line2_o, 1'b1);
        tick();
        check("R5 stays high", line2_o, 1'b1);
        check("R5 no flag0", flags[0], 1'b0);

        // R9 set wins over clear
        mode = 3'd7;
        ext_set = 5'b00001; flag_wr = 1'b1; flag_wd = 8'h04; tick();
        ext_set = 5'd0; flag_wr = 1'b0; flag_wd = 8'd0;
        check("R9 set beats clear", flags[2], 1'b1);

        // R10 / R11 directed
        ien_wr = 1'b1; ien_wd = 8'h84; tick();
        ien_wr = 1'b0;
        check("R10 set enable", ien, 7'h04);
        check("R11 summary with enabled flag", flags, 8'h84);
        ien_wr = 1'b1; ien_wd = 8'h04; tick();
        ien_wr = 1'b0;
        check("R10 clear enable", ien, 7'h00);
        check("R11 summary drops", flags, 8'h04);
        clear_flags(8'hFF);

        // Random phase for R9 R10 R11
        fm = 7'd0; im = 7'd0;
        for (int i = 0; i < 300; i++) begin
            logic       fw, iw;
            logic [7:0] fwd, iwd;
            logic [4:0] ex;
            fw  = ($urandom % 3) == 0;
            iw  = ($urandom % 3) == 0;
            fwd = 8'($urandom);
            iwd = 8'($urandom);
            ex  = 5'($urandom) & 5'($urandom);
            flag_wr = fw; flag_wd = fwd; ien_wr = iw; ien_wd = iwd; ext_set = ex;
            fm = model_flags(fm, fw, fwd, ex);
            im = model_ien(im, iw, iwd);
            tick();
            check("R9 random flags", flags[6:0], fm);
            check("R10 random enables", ien, im);
            check("R11 random summary", flags[7], |(fm & im));
        end
        flag_wr = 1'b0; ien_wr = 1'b0; ext_set = 5'd0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule